// File: doc/BRIEF.md
# Paired Compare-and-Swap Atomic Unit

This block performs an indivisible compare-and-swap on a pair of adjacent elements kept in a local memory array. One request carries two compare operands, two replacement operands, a base address (or a stack-pointer address), an element size, a byte-order flag and the two memory-ordering flags. The unit packs each operand pair into a single double-width value and reads the double-width location. It compares the two. Only when every bit matches does it write the packed replacement value back, inside the same locked sequence. The old memory contents always come back, split into the two operand slots using the same byte-order rule.

Requests enter through a valid/ready handshake. `req_ready` is high only while the unit is idle. A requester that raises `req_valid` must hold every request field steady until it sees `req_valid && req_ready` at a rising edge. The unit then drops `req_ready` until one cycle after its response. The response is a one-cycle `rsp_done` pulse and cannot be back-pressured. Its fields are valid only in that cycle. `lock` is high while the location is being read and written, so that a competing memory port can be stalled.

A request whose register indices are odd is reported as undefined. A request whose address is not aligned to the access size is aborted. Neither kind touches memory, and both hand the compare operands back unchanged.

Top module: `pair_cas_unit`

## Requirements
- R1: `req_size`=0 selects 32-bit elements and an 8-byte access. `req_size`=1 selects 64-bit elements and a 16-byte access. In 32-bit mode only bits [31:0] of each operand are used, and bits [63:32] of `rsp_first`/`rsp_second` read as zero on a normal completion.
- R2: When bit 0 of `req_cmp_idx` or bit 0 of `req_new_idx` is 1, the request completes with `rsp_undef`=1, `rsp_abort`=0 and `rsp_success`=0. Memory is not changed, and `rsp_first`/`rsp_second` return `req_cmp_first`/`req_cmp_second` unchanged. This check takes priority over the alignment check.
- R3: The compare value is packed as follows. With `req_big_endian`=1 it is {first, second}, with the first operand in the upper half. With `req_big_endian`=0 it is {second, first}, with the first operand in the lower half. The new value is packed the same way. Memory is little-endian by 32-bit word: the word at the lowest address holds bits [31:0] of the double-width value.
- R4: The packed new value is written only when the whole double-width read equals the packed compare value. `rsp_success` is 1 exactly when that write takes place. A difference in any bit, including one in the upper half only, leaves memory unchanged.
- R5: The old contents are returned unpacked. With big-endian, `rsp_first` is the upper half and `rsp_second` the lower half. With little-endian, `rsp_first` is the lower half and `rsp_second` the upper half.
- R6: When `req_base_idx`=31, `req_sp` is the access address. For any other index, `req_addr` is the access address.
- R7: When the selected address is not a multiple of the access size in bytes, the request completes with `rsp_abort`=1 and `rsp_success`=0. Memory is not changed, and `rsp_first`/`rsp_second` return the compare operands unchanged.
- R8: `rsp_acquire` and `rsp_release` return the `req_acquire`/`req_release` flags of the same request, in all four combinations.
- R9: When `req_cmp_idx` equals `req_new_idx`, memory keeps its contents whatever the new operands are.
- R10: `lock` is high in the read cycle and in the write cycle, and is low otherwise. It falls in the cycle in which `rsp_done` is high. `req_ready` is never high while `lock` is high.
- R11: Counted from the accepting edge, `rsp_done` is high for one cycle in the 1st cycle for an undefined or aborted request, in the 2nd cycle for a failed compare, and in the 3rd cycle for a successful swap.
- R12: After reset, all of memory reads as zero, `req_ready`=1, and `lock` and `rsp_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on valid && ready |
| req_size | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| req_big_endian | input | 1 | Pair packing order |
| req_acquire | input | 1 | Acquire ordering flag |
| req_release | input | 1 | Release ordering flag |
| req_cmp_idx | input | 5 | Register index of compare pair (must be even) |
| req_new_idx | input | 5 | Register index of new-value pair (must be even) |
| req_base_idx | input | 5 | Base register index, 31 selects stack pointer |
| req_addr | input | ADDR_W | General byte address |
| req_sp | input | ADDR_W | Stack-pointer byte address |
| req_cmp_first | input | 64 | First compare operand |
| req_cmp_second | input | 64 | Second compare operand |
| req_new_first | input | 64 | First new-value operand |
| req_new_second | input | 64 | Second new-value operand |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_success | output | 1 | Write was performed |
| rsp_undef | output | 1 | Illegal register indices |
| rsp_abort | output | 1 | Misaligned address |
| rsp_acquire | output | 1 | Acquire flag of the completed request |
| rsp_release | output | 1 | Release flag of the completed request |
| rsp_first | output | 64 | Old data for first slot (or restored operand) |
| rsp_second | output | 64 | Old data for second slot (or restored operand) |
| lock | output | 1 | Location locked for read/write sequence |

## Verification
A wrong packing or lane select puts wrong data in memory, and the fault stays hidden until a later request reads that location. The bench therefore compares every response against a bench-side memory model, so a corrupt word shows up at the next access to it, within a few requests. A stuck or misrouted state shows at once in the response latency and in the number of cycles `lock` stays high, both of which are checked on every request. A fault path that leaks memory data shows in the same response, because the returned operands no longer equal the ones sent in.

// File: rtl/pcas_pkg.sv
package pcas_pkg;
  localparam int ELEM_W  = 64;
  localparam int HALF_W  = ELEM_W / 2;
  localparam int PAIR_W  = 2 * ELEM_W;
  localparam int WORD_W  = 32;
  localparam int LANES   = PAIR_W / WORD_W;
  localparam int RIDX_W  = 5;
  localparam int SP_SEL  = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} cas_state_e;

  typedef struct packed {
    logic [ELEM_W-1:0] first;
    logic [ELEM_W-1:0] second;
  } slot_pair_t;

  // Combine two operands into one double-width value
  function automatic logic [PAIR_W-1:0] join_pair(input logic [ELEM_W-1:0] first,
                                                  input logic [ELEM_W-1:0] second,
                                                  input logic wide, input logic big);
    logic [PAIR_W-1:0] r;
    r = '0;
    if (wide) r = big ? {first, second} : {second, first};
    else if (big) r[ELEM_W-1:0] = {first[HALF_W-1:0], second[HALF_W-1:0]};
    else r[ELEM_W-1:0] = {second[HALF_W-1:0], first[HALF_W-1:0]};
    return r;
  endfunction

  // Split a double-width value back into the two operand slots
  function automatic slot_pair_t split_pair(input logic [PAIR_W-1:0] d,
                                            input logic wide, input logic big);
    slot_pair_t p;
    p = '0;
    if (wide) begin
      p.first  = big ? d[PAIR_W-1:ELEM_W] : d[ELEM_W-1:0];
      p.second = big ? d[ELEM_W-1:0] : d[PAIR_W-1:ELEM_W];
    end else begin
      p.first[HALF_W-1:0]  = big ? d[ELEM_W-1:HALF_W] : d[HALF_W-1:0];
      p.second[HALF_W-1:0] = big ? d[HALF_W-1:0] : d[ELEM_W-1:HALF_W];
    end
    return p;
  endfunction
endpackage

// File: rtl/pcas_decode.sv
module pcas_decode
  import pcas_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wide,
  input  logic              big,
  input  logic [RIDX_W-1:0] cmp_idx,
  input  logic [RIDX_W-1:0] new_idx,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [ADDR_W-1:0] gen_addr,
  input  logic [ADDR_W-1:0] sp_addr,
  input  logic [ELEM_W-1:0] cmp_first,
  input  logic [ELEM_W-1:0] cmp_second,
  input  logic [ELEM_W-1:0] new_first,
  input  logic [ELEM_W-1:0] new_second,
  output logic              undef,
  output logic              abort,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [PAIR_W-1:0] cmp_val,
  output logic [PAIR_W-1:0] new_val
);
  localparam int NARROW_ALIGN = $clog2(PAIR_W / 16);
  localparam int WIDE_ALIGN   = $clog2(PAIR_W / 8);

  logic misalign;

  always_comb begin
    eff_addr = (base_idx == RIDX_W'(SP_SEL)) ? sp_addr : gen_addr;
    undef    = cmp_idx[0] | new_idx[0];
    misalign = wide ? (eff_addr[WIDE_ALIGN-1:0] != '0)
                    : (eff_addr[NARROW_ALIGN-1:0] != '0);
    abort    = misalign & ~undef;
    cmp_val  = join_pair(cmp_first, cmp_second, wide, big);
    // Same register pair for compare and new value: write back what was compared
    new_val  = (cmp_idx == new_idx) ? cmp_val
                                    : join_pair(new_first, new_second, wide, big);
  end
endmodule

// File: rtl/pcas_store.sv
module pcas_store
  import pcas_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-3:0] base,
  input  logic              wide,
  input  logic              we,
  input  logic [PAIR_W-1:0] wr_data,
  output logic [PAIR_W-1:0] rd_data
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  lane_idx [LANES];
  logic [LANES-1:0]  lane_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_idx[l] = base + IDX_W'(l);
    assign lane_en[l]  = we & (wide | (l < LANES / 2));
    assign rd_data[l*WORD_W +: WORD_W] = mem[lane_idx[l]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (lane_en[l]) mem[lane_idx[l]] <= wr_data[l*WORD_W +: WORD_W];
    end
  end

  // R7: a write only ever lands on a size-aligned base
  a_r7_aligned_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (base[0] == 1'b0) && (!wide || base[1:0] == 2'b00));
endmodule

// File: rtl/pair_cas_unit.sv
module pair_cas_unit
  import pcas_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_size,
  input  logic              req_big_endian,
  input  logic              req_acquire,
  input  logic              req_release,
  input  logic [4:0]        req_cmp_idx,
  input  logic [4:0]        req_new_idx,
  input  logic [4:0]        req_base_idx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_sp,
  input  logic [63:0]       req_cmp_first,
  input  logic [63:0]       req_cmp_second,
  input  logic [63:0]       req_new_first,
  input  logic [63:0]       req_new_second,
  output logic              rsp_done,
  output logic              rsp_success,
  output logic              rsp_undef,
  output logic              rsp_abort,
  output logic              rsp_acquire,
  output logic              rsp_release,
  output logic [63:0]       rsp_first,
  output logic [63:0]       rsp_second,
  output logic              lock
);
  cas_state_e        st;
  logic              dec_undef, dec_abort;
  logic [ADDR_W-1:0] dec_addr;
  logic [PAIR_W-1:0] dec_cmp, dec_new;
  logic [PAIR_W-1:0] rd_data, rd_masked;
  logic              mem_we;

  logic              wide_q, big_q, acq_q, rel_q, undef_q, abort_q, match_q;
  logic [ADDR_W-3:0] base_q;
  logic [PAIR_W-1:0] cmp_q, new_q, old_q;
  logic [ELEM_W-1:0] opa_q, opb_q;
  slot_pair_t        old_split;

  pcas_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wide(req_size), .big(req_big_endian),
    .cmp_idx(req_cmp_idx), .new_idx(req_new_idx), .base_idx(req_base_idx),
    .gen_addr(req_addr), .sp_addr(req_sp),
    .cmp_first(req_cmp_first), .cmp_second(req_cmp_second),
    .new_first(req_new_first), .new_second(req_new_second),
    .undef(dec_undef), .abort(dec_abort), .eff_addr(dec_addr),
    .cmp_val(dec_cmp), .new_val(dec_new)
  );

  pcas_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .base(base_q), .wide(wide_q),
    .we(mem_we), .wr_data(new_q), .rd_data(rd_data)
  );

  assign rd_masked = wide_q ? rd_data : {{ELEM_W{1'b0}}, rd_data[ELEM_W-1:0]};
  assign req_ready = (st == ST_IDLE);
  assign lock      = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we    = (st == ST_WRITE);
  assign rsp_done  = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      {wide_q, big_q, acq_q, rel_q, undef_q, abort_q, match_q} <= '0;
      base_q <= '0;
      cmp_q  <= '0;
      new_q  <= '0;
      old_q  <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          wide_q  <= req_size;
          big_q   <= req_big_endian;
          acq_q   <= req_acquire;
          rel_q   <= req_release;
          undef_q <= dec_undef;
          abort_q <= dec_abort;
          match_q <= 1'b0;
          base_q  <= dec_addr[ADDR_W-1:2];
          cmp_q   <= dec_cmp;
          new_q   <= dec_new;
          opa_q   <= req_cmp_first;
          opb_q   <= req_cmp_second;
          st      <= (dec_undef || dec_abort) ? ST_DONE : ST_READ;
        end
        ST_READ: begin
          old_q   <= rd_masked;
          match_q <= (rd_masked == cmp_q);
          st      <= (rd_masked == cmp_q) ? ST_WRITE : ST_DONE;
        end
        ST_WRITE: st <= ST_DONE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign old_split   = split_pair(old_q, wide_q, big_q);
  assign rsp_undef   = undef_q;
  assign rsp_abort   = abort_q;
  assign rsp_success = match_q;
  assign rsp_acquire = acq_q;
  assign rsp_release = rel_q;
  assign rsp_first   = (undef_q || abort_q) ? opa_q : old_split.first;
  assign rsp_second  = (undef_q || abort_q) ? opb_q : old_split.second;

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R11: an accepted request closes the ready window
  a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10: lock ends exactly as the response appears
  a_r10_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> rsp_done);
  // R10: no new request is taken while locked
  a_r10_ready_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lock);
  // R4: a write is always preceded by the locked read cycle
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (lock && $past(lock)) || (lock && $past(st == ST_READ)));
  // R2/R7: a faulted request never reports success
  a_r7_fault_no_success: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && (rsp_undef || rsp_abort)) |-> !rsp_success);
  // R2: undefined and abort are exclusive
  a_r2_undef_priority: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !(rsp_undef && rsp_abort));
endmodule

// File: tb/pair_cas_unit_tb.sv
`timescale 1ns/1ps
module pair_cas_unit_tb;
  localparam int AW = 8;
  localparam int NW = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_size = 1'b0, req_big_endian = 1'b0, req_acquire = 1'b0, req_release = 1'b0;
  logic [4:0] req_cmp_idx = '0, req_new_idx = '0, req_base_idx = '0;
  logic [AW-1:0] req_addr = '0, req_sp = '0;
  logic [63:0] req_cmp_first = '0, req_cmp_second = '0, req_new_first = '0, req_new_second = '0;
  logic rsp_done, rsp_success, rsp_undef, rsp_abort, rsp_acquire, rsp_release, lock;
  logic [63:0] rsp_first, rsp_second;

  always #2.5 clk = ~clk;

  pair_cas_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_big_endian(req_big_endian),
    .req_acquire(req_acquire), .req_release(req_release),
    .req_cmp_idx(req_cmp_idx), .req_new_idx(req_new_idx), .req_base_idx(req_base_idx),
    .req_addr(req_addr), .req_sp(req_sp),
    .req_cmp_first(req_cmp_first), .req_cmp_second(req_cmp_second),
    .req_new_first(req_new_first), .req_new_second(req_new_second),
    .rsp_done(rsp_done), .rsp_success(rsp_success), .rsp_undef(rsp_undef),
    .rsp_abort(rsp_abort), .rsp_acquire(rsp_acquire), .rsp_release(rsp_release),
    .rsp_first(rsp_first), .rsp_second(rsp_second), .lock(lock)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [NW];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] pk(input logic [63:0] f, input logic [63:0] s,
                                      input logic wide, input logic big);
    if (wide) return big ? {f, s} : {s, f};
    return big ? {64'd0, f[31:0], s[31:0]} : {64'd0, s[31:0], f[31:0]};
  endfunction

  function automatic logic [127:0] mread(input int w, input logic wide);
    logic [127:0] r = '0;
    for (int l = 0; l < (wide ? 4 : 2); l++) r[l*32 +: 32] = model[(w + l) % NW];
    return r;
  endfunction

  task automatic run_req(input logic sz, input logic be, input logic acq, input logic rel,
                         input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rn,
                         input logic [AW-1:0] addr, input logic [AW-1:0] sp,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] na, input logic [63:0] nb, input string tag);
    logic [AW-1:0] ea;
    logic undef, abrt, match;
    logic [127:0] old, cv, nv;
    logic [63:0] ea_f, ea_s;
    int nbytes, elat, lat, lk;
    ea     = (rn == 5'd31) ? sp : addr;
    nbytes = sz ? 16 : 8;
    undef  = rs[0] | rt[0];
    abrt   = !undef && ((int'(ea) % nbytes) != 0);
    match  = 1'b0;
    if (undef || abrt) begin
      ea_f = a; ea_s = b; elat = 1;
    end else begin
      old = mread(int'(ea) / 4, sz);
      cv  = pk(a, b, sz, be);
      nv  = (rs == rt) ? cv : pk(na, nb, sz, be);
      match = (old == cv);
      if (match) for (int l = 0; l < (sz ? 4 : 2); l++) model[(int'(ea) / 4 + l) % NW] = nv[l*32 +: 32];
      if (sz) begin
        ea_f = be ? old[127:64] : old[63:0];
        ea_s = be ? old[63:0] : old[127:64];
      end else begin
        ea_f = {32'd0, be ? old[63:32] : old[31:0]};
        ea_s = {32'd0, be ? old[31:0] : old[63:32]};
      end
      elat = match ? 3 : 2;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", {tag, " ready idle"}, 128'(req_ready), 128'd1);
    req_size = sz; req_big_endian = be; req_acquire = acq; req_release = rel;
    req_cmp_idx = rs; req_new_idx = rt; req_base_idx = rn; req_addr = addr; req_sp = sp;
    req_cmp_first = a; req_cmp_second = b; req_new_first = na; req_new_second = nb;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; lk = 0;
    while (!rsp_done && lat < 10) begin
      if (lock) lk++;
      @(negedge clk);
      lat++;
    end
    chk(lat == elat, "R11", {tag, " latency"}, 128'(lat), 128'(elat));
    chk(lk == elat - 1 && !lock, "R10", {tag, " lock cycles"}, 128'(lk), 128'(elat - 1));
    chk(rsp_undef == undef, "R2", {tag, " undef"}, 128'(rsp_undef), 128'(undef));
    chk(rsp_abort == abrt, "R7", {tag, " abort"}, 128'(rsp_abort), 128'(abrt));
    chk(rsp_success == match, "R4", {tag, " success"}, 128'(rsp_success), 128'(match));
    chk(rsp_first == ea_f, "R5", {tag, " first slot"}, 128'(rsp_first), 128'(ea_f));
    chk(rsp_second == ea_s, "R5", {tag, " second slot"}, 128'(rsp_second), 128'(ea_s));
    chk({rsp_acquire, rsp_release} == {acq, rel}, "R8", {tag, " ordering flags"},
        128'({rsp_acquire, rsp_release}), 128'({acq, rel}));
  endtask

  // Read-only probe: compare values chosen to mismatch, so memory is untouched
  task automatic probe(input logic sz, input logic [AW-1:0] addr, input string tag);
    logic [127:0] old = mread(int'(addr) / 4, sz);
    run_req(sz, 1'b0, 1'b0, 1'b0, 5'd2, 5'd4, 5'd1, addr, '0,
            ~old[63:0], 64'd0, 64'd0, 64'd0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready && !lock && !rsp_done, "R12", "reset outputs",
        128'({req_ready, lock, rsp_done}), 128'(3'b100));
    // R12 memory zero, R1/R3/R4 wide little-endian swap
    run_req(1, 0, 0, 0, 5'd2, 5'd4, 5'd1, 8'h00, 8'h00, 0, 0,
            64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R12 zero swap");
    // R5 big-endian view of same data, failing compare
    run_req(1, 1, 1, 0, 5'd2, 5'd4, 5'd1, 8'h00, 8'h00, 1, 2, 3, 4, "R5 be readback");
    // R1 narrow little-endian match then big-endian view
    run_req(0, 0, 0, 1, 5'd6, 5'd8, 5'd3, 8'h20, 8'h00, 0, 0,
            64'hFFFF_FFFF_AAAA_0001, 64'hFFFF_FFFF_BBBB_0002, "R1 narrow swap");
    probe(0, 8'h20, "R1 narrow probe");
    run_req(0, 1, 1, 1, 5'd6, 5'd8, 5'd3, 8'h20, 8'h00, 64'hBBBB_0002, 64'hAAAA_0001,
            64'hC, 64'hD, "R3 be narrow match");
    // R4 difference only in upper half
    run_req(1, 0, 0, 0, 5'd2, 5'd4, 5'd1, 8'h00, 8'h00,
            64'h1111_2222_3333_4444, 64'h5555_6666_7777_8889, 9, 9, "R4 upper miss");
    probe(1, 8'h00, "R4 unchanged");
    // R2 odd indices, priority over misalignment
    run_req(1, 0, 0, 0, 5'd3, 5'd4, 5'd1, 8'h00, 8'h00, 64'h77, 64'h88, 1, 1, "R2 odd cmp");
    run_req(0, 1, 0, 0, 5'd2, 5'd5, 5'd1, 8'h04, 8'h00, 64'h99, 64'hAA, 1, 1, "R2 odd new");
    probe(1, 8'h00, "R2 unchanged");
    // R7 misalignment
    run_req(0, 0, 0, 0, 5'd2, 5'd4, 5'd1, 8'h24, 8'h00, 64'h1, 64'h2, 3, 4, "R7 narrow mis");
    run_req(1, 0, 0, 0, 5'd2, 5'd4, 5'd1, 8'h28, 8'h00, 64'h5, 64'h6, 7, 8, "R7 wide mis");
    // R6 stack pointer selection
    run_req(1, 0, 0, 0, 5'd2, 5'd4, 5'd31, 8'h03, 8'h40, 0, 0, 64'hABC, 64'hDEF, "R6 sp used");
    run_req(1, 0, 0, 0, 5'd2, 5'd4, 5'd31, 8'h40, 8'h48, 0, 0, 1, 1, "R6 sp misaligned");
    probe(1, 8'h40, "R6 sp target");
    // R9 same index keeps memory
    run_req(1, 0, 0, 0, 5'd10, 5'd10, 5'd1, 8'h40, 8'h00, 64'hABC, 64'hDEF,
            64'h1234, 64'h5678, "R9 same idx");
    probe(1, 8'h40, "R9 unchanged");
    // R8 all ordering combinations covered in random loop as well
    for (int k = 0; k < 4; k++)
      run_req(0, 0, k[1], k[0], 5'd2, 5'd4, 5'd1, 8'h80, 8'h00, 1, 1, 2, 2, "R8 flags");
    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic sz, be;
      logic [4:0] rs, rt, rn;
      logic [AW-1:0] ad, sp;
      logic [127:0] old;
      logic [63:0] a, b;
      sz = 1'($urandom); be = 1'($urandom);
      rs = 5'($urandom) & ((($urandom % 10) == 0) ? 5'h1F : 5'h1E);
      rt = 5'($urandom) & ((($urandom % 10) == 0) ? 5'h1F : 5'h1E);
      rn = (($urandom % 4) == 0) ? 5'd31 : 5'($urandom % 31);
      ad = 8'($urandom % 16) << 4;
      sp = 8'($urandom % 16) << 4;
      if (($urandom % 8) == 0) ad = 8'($urandom);
      if (($urandom % 8) == 0) sp = 8'($urandom);
      old = mread(int'((rn == 5'd31) ? sp : ad) / 4, sz);
      if (sz) begin
        a = be ? old[127:64] : old[63:0];
        b = be ? old[63:0] : old[127:64];
      end else begin
        a = {32'($urandom), be ? old[63:32] : old[31:0]};
        b = {32'($urandom), be ? old[31:0] : old[63:32]};
      end
      if ($urandom % 2) a[$urandom % (sz ? 64 : 32)] ^= 1'b1;
      run_req(sz, be, 1'($urandom), 1'($urandom), rs, rt, rn, ad, sp, a, b,
              {$urandom, $urandom}, {$urandom, $urandom}, "R3 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule